// File: doc/BRIEF.md
# Dual-Mode Programmable Feedback Divider

This block divides a local-oscillator clock by a programmed ratio and emits one feedback pulse per division period for a PLL phase comparator. The oscillator is modelled as a cycle enable (`lo_en`) in the system clock domain, so the divider counts enabled cycles, not clock edges. Three paths exist. The high-band path puts a fixed divide-by-two stage ahead of a 16-bit counter, giving a total ratio of twice the setting. The mid-band path runs the same 16-bit counter directly. The low-band path uses a separate 12-bit counter.

A control bank supplies a divisor word, two path bits and a one-cycle load strobe. The first load after reset starts the divider at once. Later loads are held and take effect only at the next terminal count, so no period is ever cut short. A setting below the legal floor of the selected path is raised to that floor, and a flag reports the correction.

Top module: `pll_fb_divider`

## Requirements
- R1: After reset `fb_pulse` and `clamp_err` are 0, and no pulse appears, whatever `lo_en` does, until the first `load`.
- R2: With `band_hi`=1 (`sens_direct` ignored) the period is 2×N enabled cycles, where N is the 16-bit `div_word`.
- R3: With `band_hi`=0 and `sens_direct`=1 the period is N enabled cycles, with N the 16-bit `div_word`.
- R4: With `band_hi`=0 and `sens_direct`=0 the period is N enabled cycles, with N taken from `div_word[11:0]`; bits 15:12 are ignored.
- R5: On the 16-bit paths a word below 272 acts as 272, and `clamp_err` reads 1 in the cycle after that load.
- R6: On the 12-bit path a value of `div_word[11:0]` below 4 acts as 4, and `clamp_err` reads 1 in the cycle after that load.
- R7: `clamp_err` changes only in the cycle after a load, and it is cleared by a load of a legal setting.
- R8: A load while the divider runs does not disturb the period in progress. The new ratio and path apply from the next terminal count on.
- R9: Only enabled cycles are counted. Each pulse is one clock wide and is registered: it appears in the cycle after the enabled cycle that completes the period.
- R10: The first load starts counting at once. Enabled cycles before it are not counted, and the R-th enabled cycle after the load cycle ends the first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_en | input | 1 | Oscillator cycle enable (one count per high cycle) |
| div_word | input | 16 | Divisor setting |
| band_hi | input | 1 | 1 selects the high-band path with the ÷2 stage |
| sens_direct | input | 1 | With band_hi=0: 1 selects the 16-bit counter, 0 the 12-bit counter |
| load | input | 1 | One-cycle strobe that captures divisor and path |
| fb_pulse | output | 1 | Divided feedback pulse, one clock wide |
| clamp_err | output | 1 | The last load was raised to the path minimum |

## Verification
Take the load edge as edge 0. A period of R enabled cycles then shows its pulse right after the edge that samples the R-th enable, and the next pulse R enables later. The flag is due one edge after the load. The bench numbers the edges after each load, drives inputs on falling edges and samples one time unit after each rising edge, so it records the exact edge index of every pulse. It compares that index with R and 2R as derived from the requirements. For gapped enables and mid-run loads, the bench works out the expected index from the enable pattern.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
    // Path through the divider
    typedef enum logic [1:0] {
        PATH_LOW  = 2'd0,
        PATH_MID  = 2'd1,
        PATH_HIGH = 2'd2
    } fb_path_e;

    localparam int WIDE_W_DEF     = 16;
    localparam int NARROW_W_DEF   = 12;
    localparam int WIDE_MIN_DEF   = 272;
    localparam int NARROW_MIN_DEF = 4;
endpackage

// File: rtl/fbd_prescale2.sv
// Divide-by-two stage: phase toggles on each enabled cycle, cleared on restart.
module fbd_prescale2 (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic phase
);
    logic phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (clr)     phase_d = 1'b0;
        else if (en) phase_d = ~phase_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;
endmodule

// File: rtl/fbd_down_cnt.sv
// Loadable down counter with a zero flag.
module fbd_down_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ld)       cnt_d = ld_val;
        else if (dec) cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pll_fb_divider.sv
module pll_fb_divider
    import fbd_pkg::*;
#(
    parameter int WIDE_W     = WIDE_W_DEF,
    parameter int NARROW_W   = NARROW_W_DEF,
    parameter int WIDE_MIN   = WIDE_MIN_DEF,
    parameter int NARROW_MIN = NARROW_MIN_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_en,
    input  logic [WIDE_W-1:0] div_word,
    input  logic              band_hi,
    input  logic              sens_direct,
    input  logic              load,
    output logic              fb_pulse,
    output logic              clamp_err
);
    localparam int PAD_W = WIDE_W - NARROW_W;

    typedef struct packed {
        fb_path_e          path;
        logic [WIDE_W-1:0] n;
    } cfg_t;

    typedef struct packed {
        logic run;
        cfg_t act;
        cfg_t pend;
        logic err;
        logic pulse;
    } state_t;

    state_t s_d, s_q;

    // Decoded request from the control inputs
    cfg_t                fresh;
    logic                fresh_err;
    logic [NARROW_W-1:0] narrow_word;

    // Datapath handshakes
    cfg_t                nxt;
    logic                start, term, tick, swap;
    logic                pre_phase, pre_en;
    logic                wide_zero, narrow_zero;
    logic                wide_ld, wide_dec, narrow_ld, narrow_dec;
    logic [WIDE_W-1:0]   wide_val;
    logic [NARROW_W-1:0] narrow_val;

    // Request decode and floor clamp
    always_comb begin
        narrow_word = div_word[NARROW_W-1:0];
        fresh_err   = 1'b0;
        if (band_hi)          fresh.path = PATH_HIGH;
        else if (sens_direct) fresh.path = PATH_MID;
        else                  fresh.path = PATH_LOW;

        if (fresh.path == PATH_LOW) begin
            if (narrow_word < NARROW_W'(NARROW_MIN)) begin
                fresh.n   = WIDE_W'(NARROW_MIN);
                fresh_err = 1'b1;
            end else begin
                fresh.n = {{PAD_W{1'b0}}, narrow_word};
            end
        end else begin
            if (div_word < WIDE_W'(WIDE_MIN)) begin
                fresh.n   = WIDE_W'(WIDE_MIN);
                fresh_err = 1'b1;
            end else begin
                fresh.n = div_word;
            end
        end
    end

    // Counting control
    always_comb begin
        start = load & ~s_q.run;
        if (s_q.act.path == PATH_HIGH) tick = lo_en & pre_phase;
        else                           tick = lo_en;
        term  = s_q.run & tick &
                ((s_q.act.path == PATH_LOW) ? narrow_zero : wide_zero);
        swap  = start | term;
        nxt   = swap ? (load ? fresh : s_q.pend) : s_q.act;

        pre_en     = s_q.run & lo_en & (s_q.act.path == PATH_HIGH);
        wide_val   = nxt.n - WIDE_W'(1);
        narrow_val = nxt.n[NARROW_W-1:0] - NARROW_W'(1);
        wide_ld    = swap & (nxt.path != PATH_LOW);
        narrow_ld  = swap & (nxt.path == PATH_LOW);
        wide_dec   = s_q.run & tick & ~term & (s_q.act.path != PATH_LOW);
        narrow_dec = s_q.run & tick & ~term & (s_q.act.path == PATH_LOW);
    end

    // Next-state
    always_comb begin
        s_d       = s_q;
        s_d.pulse = term;
        if (start) s_d.run = 1'b1;
        if (swap)  s_d.act = nxt;
        if (load) begin
            s_d.pend = fresh;
            s_d.err  = fresh_err;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    fbd_prescale2 u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (pre_en),
        .clr   (swap),
        .phase (pre_phase)
    );

    fbd_down_cnt #(.W(WIDE_W)) u_wide (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (wide_ld),
        .ld_val (wide_val),
        .dec    (wide_dec),
        .zero   (wide_zero)
    );

    fbd_down_cnt #(.W(NARROW_W)) u_narrow (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (narrow_ld),
        .ld_val (narrow_val),
        .dec    (narrow_dec),
        .zero   (narrow_zero)
    );

    assign fb_pulse  = s_q.pulse;
    assign clamp_err = s_q.err;
endmodule

// File: rtl/pll_fb_divider_chk.sv
module pll_fb_divider_chk #(
    parameter int WIDE_W     = 16,
    parameter int NARROW_W   = 12,
    parameter int WIDE_MIN   = 272,
    parameter int NARROW_MIN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lo_en,
    input logic [WIDE_W-1:0] div_word,
    input logic              band_hi,
    input logic              sens_direct,
    input logic              load,
    input logic              fb_pulse,
    input logic              clamp_err
);
    logic seen_load_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    seen_load_q <= 1'b0;
        else if (load) seen_load_q <= 1'b1;
    end

    // R1: silent until the first load
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_load_q |-> !fb_pulse);

    // R9: pulse is one clock wide
    a_r9_single_width: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);

    // R9: a pulse follows an enabled cycle
    a_r9_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |-> $past(lo_en));

    // R7: flag moves only after a load
    a_r7_err_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(clamp_err));

    // R5: wide-path floor raises the flag
    a_r5_wide_clamp_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (band_hi || sens_direct) && (div_word < WIDE_W'(WIDE_MIN)))
        |=> clamp_err);

    // R6: narrow-path floor raises the flag
    a_r6_narrow_clamp_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !band_hi && !sens_direct &&
         (div_word[NARROW_W-1:0] < NARROW_W'(NARROW_MIN))) |=> clamp_err);
endmodule

bind pll_fb_divider pll_fb_divider_chk #(
    .WIDE_W     (WIDE_W),
    .NARROW_W   (NARROW_W),
    .WIDE_MIN   (WIDE_MIN),
    .NARROW_MIN (NARROW_MIN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lo_en       (lo_en),
    .div_word    (div_word),
    .band_hi     (band_hi),
    .sens_direct (sens_direct),
    .load        (load),
    .fb_pulse    (fb_pulse),
    .clamp_err   (clamp_err)
);

// File: tb/pll_fb_divider_tb.sv
module pll_fb_divider_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lo_en = 1'b0;
    logic [15:0] div_word = '0;
    logic        band_hi = 1'b0;
    logic        sens_direct = 1'b0;
    logic        load = 1'b0;
    logic        fb_pulse;
    logic        clamp_err;

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_fb_divider u_dut (
        .clk(clk), .rst_n(rst_n), .lo_en(lo_en), .div_word(div_word),
        .band_hi(band_hi), .sens_direct(sens_direct), .load(load),
        .fb_pulse(fb_pulse), .clamp_err(clamp_err)
    );

    task automatic check_eq(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lo_en = 1'b0; load = 1'b0;
        div_word = '0; band_hi = 1'b0; sens_direct = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drives one load cycle; returns at the falling edge after the load edge.
    task automatic load_cfg(logic [15:0] w, logic hi, logic sens);
        @(negedge clk);
        div_word = w; band_hi = hi; sens_direct = sens;
        load = 1'b1; lo_en = 1'b0;
        @(negedge clk);
        load = 1'b0;
    endtask

    // Counts edges after the load edge; records pulse indices.
    // gap=1 enables only odd edges. mid_at>0 issues a load at that edge.
    task automatic measure(int limit, bit gap, int mid_at,
                           logic [15:0] mw, logic mhi, logic msens,
                           output int first, output int second,
                           output int count, output int adjacent);
        bit prev = 0;
        first = 0; second = 0; count = 0; adjacent = 0;
        for (int i = 1; i <= limit; i++) begin
            lo_en = gap ? ((i % 2) == 1) : 1'b1;
            if (i == mid_at) begin
                div_word = mw; band_hi = mhi; sens_direct = msens; load = 1'b1;
            end else begin
                load = 1'b0;
            end
            @(posedge clk);
            #1;
            if (fb_pulse) begin
                count++;
                if (prev) adjacent++;
                if (first == 0) first = i;
                else if (second == 0) second = i;
            end
            prev = fb_pulse;
            @(negedge clk);
        end
        lo_en = 1'b0; load = 1'b0;
    endtask

    task automatic t_reset_idle();
        int f, s, c, a;
        do_reset();
        check_eq("R1", "pulse after reset", int'(fb_pulse), 0);
        check_eq("R1", "flag after reset", int'(clamp_err), 0);
        c = 0;
        lo_en = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(posedge clk); #1;
            if (fb_pulse) c++;
            @(negedge clk);
        end
        lo_en = 1'b0;
        check_eq("R1", "pulses before first load", c, 0);
        load_cfg(16'd272, 1'b0, 1'b1);
        measure(300, 0, 0, '0, 0, 0, f, s, c, a);
        check_eq("R10", "first pulse edge after start", f, 272);
    endtask

    task automatic t_high();
        int f, s, c, a;
        do_reset();
        load_cfg(16'd300, 1'b1, 1'b0);
        measure(1202, 0, 0, '0, 0, 0, f, s, c, a);
        check_eq("R2", "high first pulse", f, 600);
        check_eq("R2", "high second pulse", s, 1200);
        check_eq("R9", "high pulse count", c, 2);
    endtask

    task automatic t_mid();
        int f, s, c, a;
        do_reset();
        load_cfg(16'd1000, 1'b0, 1'b1);
        measure(2002, 0, 0, '0, 0, 0, f, s, c, a);
        check_eq("R3", "mid first pulse", f, 1000);
        check_eq("R3", "mid second pulse", s, 2000);
    endtask

    task automatic t_low();
        int f, s, c, a;
        do_reset();
        load_cfg(16'hF00A, 1'b0, 1'b0);
        check_eq("R4", "flag for legal low word", int'(clamp_err), 0);
        measure(22, 0, 0, '0, 0, 0, f, s, c, a);
        check_eq("R4", "low first pulse (upper bits ignored)", f, 10);
        check_eq("R4", "low second pulse", s, 20);
        check_eq("R9", "low pulses adjacent", a, 0);
    endtask

    task automatic t_wide_clamp();
        int f, s, c, a;
        do_reset();
        load_cfg(16'd5, 1'b1, 1'b1);
        check_eq("R5", "flag after high clamp", int'(clamp_err), 1);
        measure(1090, 0, 0, '0, 0, 0, f, s, c, a);
        check_eq("R5", "clamped high first pulse", f, 544);
        check_eq("R5", "clamped high second pulse", s, 1088);
        do_reset();
        load_cfg(16'd100, 1'b0, 1'b1);
        check_eq("R5", "flag after mid clamp", int'(clamp_err), 1);
        measure(274, 0, 0, '0, 0, 0, f, s, c, a);
        check_eq("R5", "clamped mid first pulse", f, 272);
    endtask

    task automatic t_narrow_clamp();
        int f, s, c, a;
        do_reset();
        load_cfg(16'h1002, 1'b0, 1'b0);
        check_eq("R6", "flag after low clamp", int'(clamp_err), 1);
        measure(10, 0, 0, '0, 0, 0, f, s, c, a);
        check_eq("R6", "clamped low first pulse", f, 4);
        check_eq("R6", "clamped low second pulse", s, 8);
    endtask

    task automatic t_midrun_load();
        int f, s, c, a;
        do_reset();
        load_cfg(16'd200, 1'b0, 1'b1);
        check_eq("R7", "flag set by clamped load", int'(clamp_err), 1);
        measure(284, 0, 20, 16'd10, 1'b0, 1'b0, f, s, c, a);
        check_eq("R8", "old period completes", f, 272);
        check_eq("R8", "new ratio from terminal count", s, 282);
        check_eq("R7", "flag cleared by legal load", int'(clamp_err), 0);
    endtask

    task automatic t_gapped();
        int f, s, c, a;
        do_reset();
        load_cfg(16'd300, 1'b0, 1'b1);
        measure(1201, 1, 0, '0, 0, 0, f, s, c, a);
        check_eq("R9", "gapped first pulse", f, 599);
        check_eq("R9", "gapped second pulse", s, 1199);
        check_eq("R9", "gapped pulses adjacent", a, 0);
    endtask

    initial begin
        t_reset_idle();
        t_high();
        t_mid();
        t_low();
        t_wide_clamp();
        t_narrow_clamp();
        t_midrun_load();
        t_gapped();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end
endmodule